// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block drives a two-line, sixteen-column character display through an 8-bit parallel data bus and three control lines: register select (0 picks the instruction register, 1 picks the character register), read/write, and an enable strobe. When reset is released, the block runs a fixed power-up recipe. This recipe has a long settling delay, four function-set writes that are each followed by their own delay, then display off, display on and entry mode set. After that it accepts one request at a time on a valid/ready port. A request carries a register-select bit and an 8-bit payload.

Each write has three phases in order. First the select lines and data are set up while enable is low. Then enable is held high for a fixed number of cycles. Then the data stays driven for a hold time after enable falls. After the hold, the block counts an execution wait that depends on the instruction. Clear and return-home get a long wait and everything else gets a short one. The data pins are shared with memory devices, so the block drives them only during the setup, strobe and hold of its own write. The pins float at all other times, and a separate drive-enable output shows when they are driven.

All cycle counts are parameters. By default they are computed from the system clock frequency and, for the execution waits, from the display's internal oscillator frequency. A build option makes the block poll the display's busy flag instead of waiting a fixed time after user requests. This option is off by default.

Top module: `lcd_cmd_seq`

## Requirements
- R1: While reset is asserted, reqReady, lcdEn, lcdRs, lcdRw and lcdDriveEn are all 0, and this holds at once when reset is asserted in the middle of a transfer.
- R2: The first enable pulse after reset release rises exactly POWER_CYC + SETUP_CYC cycles after release.
- R3: The power-up writes carry these bytes in this order, all with register select 0 and read/write 0: 0x38 four times (8-bit bus, two lines, 5x7 font), then 0x08 (display off), then 0x0C (display on), then 0x06 (cursor increments, no shift).
- R4: After the enable of each power-up write falls, the wait before the next write's setup is HOLD_CYC cycles of hold followed by, in order, INIT_A_CYC, INIT_B_CYC, INIT_C_CYC, EXEC_SHORT_CYC, EXEC_SHORT_CYC and EXEC_SHORT_CYC cycles with the bus released.
- R5: reqReady stays 0 throughout power-up. It first rises HOLD_CYC + EXEC_SHORT_CYC cycles after the enable of the entry-mode write falls.
- R6: A request is taken in a cycle where reqValid and reqReady are both 1. reqReady drops in the next cycle, and the following enable pulse shows the request's select bit on lcdRs, 0 on lcdRw and its payload on lcdData.
- R7: An instruction (select 0) whose payload is 0x01, 0x02 or 0x03 (clear or return home) is followed by EXEC_LONG_CYC wait cycles, so reqReady rises HOLD_CYC + EXEC_LONG_CYC cycles after enable falls.
- R8: Every other instruction and every character write is followed by EXEC_SHORT_CYC wait cycles, so reqReady rises HOLD_CYC + EXEC_SHORT_CYC cycles after enable falls.
- R9: Before enable rises, lcdDriveEn is high with enable low for exactly SETUP_CYC cycles, with lcdRs and lcdRw stable. Enable stays high for exactly PULSE_CYC cycles. The data stays driven for HOLD_CYC cycles after enable falls.
- R10: lcdDriveEn is 0 during every execution wait and whenever reqReady is 1.
- R11: A reqValid pulse while reqReady is 0 is dropped: no enable pulse follows it, and the next accepted request is the one that appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can take a request |
| reqRs | input | 1 | Request target: 0 instruction, 1 character |
| reqByte | input | 8 | Request payload |
| lcdRs | output | 1 | Display register select |
| lcdRw | output | 1 | Display read/write (1 = read) |
| lcdEn | output | 1 | Display enable strobe |
| lcdData | inout | 8 | Shared display data bus, floating when not driven |
| lcdDriveEn | output | 1 | High while the block drives lcdData |

## Verification
A wrong init step index or a wrong wait selection does not corrupt any data. It only moves an enable edge or changes a byte, so the bench measures every gap between strobes down to the cycle and compares each strobed byte, and any error shows within one transfer. A counter that is loaded with the wrong length changes the setup, pulse or hold count on the very next transfer. A control state that gets stuck in a driving phase shows up as lcdDriveEn high during the wait that follows, or while reqReady is high.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    ST_POWER, ST_SETUP, ST_PULSE, ST_HOLD, ST_WAIT, ST_IDLE
  } seqState_e;

  typedef enum logic [2:0] {
    LEN_SETUP, LEN_PULSE, LEN_HOLD, LEN_EXEC, LEN_POWER
  } cntLen_e;

  typedef enum logic [2:0] {
    EW_INIT_A, EW_INIT_B, EW_INIT_C, EW_SHORT, EW_LONG
  } execWait_e;

  typedef struct packed {
    logic    loadCnt;
    cntLen_e lenSel;
    logic    capReq;
    logic    capInit;
    logic    sampleBusy;
    logic    readPhase;
  } seqStrobe_t;

  localparam int INIT_STEPS = 7;
  localparam logic [7:0] CMD_FUNC_8BIT_2LINE = 8'h38;
  localparam logic [7:0] CMD_DISPLAY_OFF     = 8'h08;
  localparam logic [7:0] CMD_DISPLAY_ON      = 8'h0C;
  localparam logic [7:0] CMD_ENTRY_INC       = 8'h06;

  function automatic logic [7:0] initByte(input logic [2:0] step);
    case (step)
      3'd0, 3'd1, 3'd2, 3'd3: initByte = CMD_FUNC_8BIT_2LINE;
      3'd4:                   initByte = CMD_DISPLAY_OFF;
      3'd5:                   initByte = CMD_DISPLAY_ON;
      default:                initByte = CMD_ENTRY_INC;
    endcase
  endfunction

  function automatic execWait_e initWait(input logic [2:0] step);
    case (step)
      3'd0:    initWait = EW_INIT_A;
      3'd1:    initWait = EW_INIT_B;
      3'd2:    initWait = EW_INIT_C;
      default: initWait = EW_SHORT;
    endcase
  endfunction

  // Clear and return-home instructions need the long execution time.
  function automatic logic needsLongWait(input logic rs, input logic [7:0] b);
    needsLongWait = !rs && (b[7:2] == 6'd0) && (b[1:0] != 2'd0);
  endfunction

  // Round a duration in nanoseconds up to whole clock cycles, at least one.
  function automatic int nsToCycles(input longint clkHz, input longint ns);
    longint c;
    c = (clkHz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    nsToCycles = (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int maxInt(input int a, input int b);
    maxInt = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int CNT_W          = 20,
  parameter int SETUP_CYC      = 2,
  parameter int PULSE_CYC      = 12,
  parameter int HOLD_CYC       = 1,
  parameter int POWER_CYC      = 750000,
  parameter int INIT_A_CYC     = 205000,
  parameter int INIT_B_CYC     = 5000,
  parameter int INIT_C_CYC     = 250000,
  parameter int EXEC_SHORT_CYC = 2000,
  parameter int EXEC_LONG_CYC  = 82000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       reqRs,
  input  logic [7:0] reqByte,
  input  logic [2:0] initIdx,
  input  logic       busyIn,
  output logic       cntDone,
  output logic       busyFlag,
  output logic       lcdRs,
  output logic [7:0] dataOut
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lenValue;
  logic             rsReg;
  logic [7:0]       byteReg;
  execWait_e        waitSel;

  always_comb begin
    case (strobe.lenSel)
      LEN_SETUP: lenValue = CNT_W'(SETUP_CYC - 1);
      LEN_PULSE: lenValue = CNT_W'(PULSE_CYC - 1);
      LEN_HOLD:  lenValue = CNT_W'(HOLD_CYC - 1);
      LEN_POWER: lenValue = CNT_W'(POWER_CYC - 1);
      default: begin
        case (waitSel)
          EW_INIT_A: lenValue = CNT_W'(INIT_A_CYC - 1);
          EW_INIT_B: lenValue = CNT_W'(INIT_B_CYC - 1);
          EW_INIT_C: lenValue = CNT_W'(INIT_C_CYC - 1);
          EW_LONG:   lenValue = CNT_W'(EXEC_LONG_CYC - 1);
          default:   lenValue = CNT_W'(EXEC_SHORT_CYC - 1);
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_W'(POWER_CYC - 1);
    end else if (strobe.loadCnt) begin
      cnt <= lenValue;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rsReg   <= 1'b0;
      byteReg <= 8'h00;
      waitSel <= EW_SHORT;
    end else if (strobe.capInit) begin
      rsReg   <= 1'b0;
      byteReg <= initByte(initIdx);
      waitSel <= initWait(initIdx);
    end else if (strobe.capReq) begin
      rsReg   <= reqRs;
      byteReg <= reqByte;
      waitSel <= needsLongWait(reqRs, reqByte) ? EW_LONG : EW_SHORT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyFlag <= 1'b0;
    end else if (strobe.sampleBusy) begin
      busyFlag <= busyIn;
    end
  end

  assign cntDone = (cnt == '0);
  assign lcdRs   = rsReg & ~strobe.readPhase;
  assign dataOut = byteReg;

endmodule

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int USE_BUSY = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cntDone,
  input  logic       busyFlag,
  output logic       reqReady,
  output seqStrobe_t strobe,
  output logic [2:0] initIdx,
  output logic       lcdEn,
  output logic       lcdRw,
  output logic       dataOe
);

  localparam logic [2:0] LAST_STEP = 3'(INIT_STEPS - 1);

  seqState_e  state, stateNext;
  logic [2:0] step, stepNext;
  logic       initMode, initNext;
  logic       readMode, readNext;
  logic       inXfer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_POWER;
      step     <= 3'd0;
      initMode <= 1'b1;
      readMode <= 1'b0;
    end else begin
      state    <= stateNext;
      step     <= stepNext;
      initMode <= initNext;
      readMode <= readNext;
    end
  end

  always_comb begin
    stateNext         = state;
    stepNext          = step;
    initNext          = initMode;
    readNext          = readMode;
    strobe            = '0;
    strobe.lenSel     = LEN_SETUP;
    strobe.readPhase  = readMode;
    case (state)
      ST_POWER: begin
        if (cntDone) begin
          strobe.capInit = 1'b1;
          strobe.loadCnt = 1'b1;
          strobe.lenSel  = LEN_SETUP;
          stateNext      = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cntDone) begin
          strobe.loadCnt = 1'b1;
          strobe.lenSel  = LEN_PULSE;
          stateNext      = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (cntDone) begin
          strobe.loadCnt    = 1'b1;
          strobe.lenSel     = LEN_HOLD;
          strobe.sampleBusy = readMode;
          stateNext         = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (cntDone) begin
          if (readMode) begin
            if (busyFlag) begin
              strobe.loadCnt = 1'b1;
              strobe.lenSel  = LEN_SETUP;
              stateNext      = ST_SETUP;
            end else begin
              readNext  = 1'b0;
              stateNext = ST_IDLE;
            end
          end else if ((USE_BUSY != 0) && !initMode) begin
            readNext       = 1'b1;
            strobe.loadCnt = 1'b1;
            strobe.lenSel  = LEN_SETUP;
            stateNext      = ST_SETUP;
          end else begin
            strobe.loadCnt = 1'b1;
            strobe.lenSel  = LEN_EXEC;
            stateNext      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cntDone) begin
          if (initMode) begin
            if (step == LAST_STEP) begin
              initNext  = 1'b0;
              stateNext = ST_IDLE;
            end else begin
              stepNext       = 3'(step + 3'd1);
              strobe.capInit = 1'b1;
              strobe.loadCnt = 1'b1;
              strobe.lenSel  = LEN_SETUP;
              stateNext      = ST_SETUP;
            end
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: begin
        if (reqValid) begin
          strobe.capReq  = 1'b1;
          strobe.loadCnt = 1'b1;
          strobe.lenSel  = LEN_SETUP;
          stateNext      = ST_SETUP;
        end
      end
    endcase
  end

  assign initIdx  = stepNext;
  assign inXfer   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
  assign reqReady = (state == ST_IDLE);
  assign lcdEn    = (state == ST_PULSE);
  assign lcdRw    = inXfer && readMode;
  assign dataOe   = inXfer && !readMode;

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> dataOe && !lcdEn && !reqReady); // R6

  AST_INIT_NO_READY: assert property (@(posedge clk) disable iff (!rstN)
    initMode |-> !reqReady); // R5

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter int CLK_HZ         = 50_000_000,
  parameter int OSC_KHZ        = 250,
  parameter int USE_BUSY       = 0,
  parameter int SETUP_CYC      = nsToCycles(CLK_HZ, 40),
  parameter int PULSE_CYC      = nsToCycles(CLK_HZ, 230),
  parameter int HOLD_CYC       = nsToCycles(CLK_HZ, 10),
  parameter int POWER_CYC      = nsToCycles(CLK_HZ, 15_000_000),
  parameter int INIT_A_CYC     = nsToCycles(CLK_HZ, 4_100_000),
  parameter int INIT_B_CYC     = nsToCycles(CLK_HZ, 100_000),
  parameter int INIT_C_CYC     = nsToCycles(CLK_HZ, 5_000_000),
  parameter int EXEC_SHORT_CYC = nsToCycles(CLK_HZ, 40_000 * 250 / OSC_KHZ),
  parameter int EXEC_LONG_CYC  = nsToCycles(CLK_HZ, 1_640_000 * 250 / OSC_KHZ)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       reqRs,
  input  logic [7:0] reqByte,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn,
  inout  wire  [7:0] lcdData,
  output logic       lcdDriveEn
);

  localparam int MAX_CYC = maxInt(POWER_CYC, maxInt(maxInt(INIT_A_CYC, INIT_B_CYC),
                             maxInt(INIT_C_CYC, maxInt(EXEC_LONG_CYC, EXEC_SHORT_CYC))));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqStrobe_t strobe;
  logic       cntDone;
  logic       busyFlag;
  logic [2:0] initIdx;
  logic [7:0] dpByte;

  lcd_seq_ctrl #(.USE_BUSY(USE_BUSY)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cntDone  (cntDone),
    .busyFlag (busyFlag),
    .reqReady (reqReady),
    .strobe   (strobe),
    .initIdx  (initIdx),
    .lcdEn    (lcdEn),
    .lcdRw    (lcdRw),
    .dataOe   (lcdDriveEn)
  );

  lcd_seq_dp #(
    .CNT_W          (CNT_W),
    .SETUP_CYC      (SETUP_CYC),
    .PULSE_CYC      (PULSE_CYC),
    .HOLD_CYC       (HOLD_CYC),
    .POWER_CYC      (POWER_CYC),
    .INIT_A_CYC     (INIT_A_CYC),
    .INIT_B_CYC     (INIT_B_CYC),
    .INIT_C_CYC     (INIT_C_CYC),
    .EXEC_SHORT_CYC (EXEC_SHORT_CYC),
    .EXEC_LONG_CYC  (EXEC_LONG_CYC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqRs    (reqRs),
    .reqByte  (reqByte),
    .initIdx  (initIdx),
    .busyIn   (lcdData[7]),
    .cntDone  (cntDone),
    .busyFlag (busyFlag),
    .lcdRs    (lcdRs),
    .dataOut  (dpByte)
  );

  assign lcdData = lcdDriveEn ? dpByte : 8'bzzzz_zzzz;

  AST_EN_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lcdEn) |-> $stable(lcdRs) && $stable(lcdRw) && $past(lcdDriveEn || lcdRw)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcdEn) && !lcdRw |-> lcdDriveEn && $stable(dpByte)); // R9

  AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !lcdDriveEn && !lcdEn); // R10

endmodule

// File: tb/lcd_cmd_seq_test.sv
module lcd_cmd_seq_test;

  localparam int CLK_PERIOD = 20;
  // Strobe timing expected at a 20 ns clock: 40 ns, 230 ns and 10 ns rounded up.
  localparam int S_CYC = 2;
  localparam int P_CYC = 12;
  localparam int H_CYC = 1;
  localparam int PWR   = 300;
  localparam int WA    = 120;
  localparam int WB    = 40;
  localparam int WC    = 150;
  localparam int WS    = 30;
  localparam int WL    = 200;

  // {rs, payload, long-wait expected}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 8'h01, 1'b1},
    {1'b1, 8'h48, 1'b0},
    {1'b0, 8'h02, 1'b1},
    {1'b0, 8'h03, 1'b1},
    {1'b0, 8'hC0, 1'b0},
    {1'b1, 8'h01, 1'b0},
    {1'b0, 8'h0F, 1'b0},
    {1'b0, 8'h04, 1'b0}
  };

  localparam logic [7:0] INIT_BYTES [7] = '{8'h38, 8'h38, 8'h38, 8'h38, 8'h08, 8'h0C, 8'h06};
  localparam int         INIT_WAITS [7] = '{WA, WB, WC, WS, WS, WS, WS};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqRs = 1'b0;
  logic [7:0] reqByte = 8'h00;
  wire        reqReady, lcdRs, lcdRw, lcdEn, lcdDriveEn;
  wire  [7:0] lcdBus;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  lcd_cmd_seq #(
    .POWER_CYC(PWR), .INIT_A_CYC(WA), .INIT_B_CYC(WB), .INIT_C_CYC(WC),
    .EXEC_SHORT_CYC(WS), .EXEC_LONG_CYC(WL)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRs(reqRs), .reqByte(reqByte), .lcdRs(lcdRs), .lcdRw(lcdRw),
    .lcdEn(lcdEn), .lcdData(lcdBus), .lcdDriveEn(lcdDriveEn)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic watchTransfer(input string byteTag, input string waitTag, input logic expRs,
                               input logic [7:0] expByte, input int expWait, output int leadCnt);
    int setupCnt = 0;
    int pulseCnt = 0;
    int holdCnt = 0;
    int waitCnt = 0;
    leadCnt = 0;
    while (!lcdEn) begin
      if (lcdDriveEn) setupCnt++; else setupCnt = 0;
      leadCnt++;
      @(negedge clk);
    end
    checkVal("R9 setup cycles", setupCnt, S_CYC);
    checkVal({byteTag, " data byte"}, int'(lcdBus), int'(expByte));
    checkVal({byteTag, " rs"}, int'(lcdRs), int'(expRs));
    checkVal({byteTag, " rw"}, int'(lcdRw), 0);
    while (lcdEn) begin
      pulseCnt++;
      @(negedge clk);
    end
    checkVal("R9 pulse cycles", pulseCnt, P_CYC);
    while (lcdDriveEn && !lcdEn) begin
      holdCnt++;
      @(negedge clk);
    end
    checkVal("R9 hold cycles", holdCnt, H_CYC);
    while (!lcdDriveEn && !reqReady && !lcdEn) begin
      waitCnt++;
      @(negedge clk);
    end
    checkVal({waitTag, " wait cycles"}, waitCnt, expWait);
  endtask

  task automatic sendReq(input logic rs, input logic [7:0] b);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqRs    = rs;
    reqByte  = b;
    @(negedge clk);
    reqValid = 1'b0;
    reqByte  = 8'hA5;
    checkVal("R6 ready drops after accept", int'(reqReady), 0);
  endtask

  initial begin
    int lead;
    int rises;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1 ready in reset", int'(reqReady), 0);
    checkVal("R1 en in reset", int'(lcdEn), 0);
    checkVal("R1 drive in reset", int'(lcdDriveEn), 0);
    checkVal("R1 rs in reset", int'(lcdRs), 0);
    checkVal("R1 rw in reset", int'(lcdRw), 0);
    rstN = 1'b1;

    for (int i = 0; i < 7; i++) begin
      watchTransfer("R3", (i == 6) ? "R5" : "R4", 1'b0, INIT_BYTES[i], INIT_WAITS[i], lead);
      if (i == 0) checkVal("R2 first strobe delay", lead, PWR + S_CYC);
      if (i < 6) checkVal("R5 not ready during init", int'(reqReady), 0);
    end
    checkVal("R5 ready after init", int'(reqReady), 1);
    checkVal("R10 bus free when ready", int'(lcdDriveEn), 0);

    for (int i = 0; i < 8; i++) begin
      sendReq(VEC[i][9], VEC[i][8:1]);
      watchTransfer("R6", VEC[i][0] ? "R7" : "R8", VEC[i][9], VEC[i][8:1],
                    VEC[i][0] ? WL : WS, lead);
      checkVal("R10 ready after wait", int'(reqReady), 1);
      checkVal("R10 bus free when ready", int'(lcdDriveEn), 0);
    end

    // R11: valid while busy is dropped
    sendReq(1'b1, 8'h41);
    while (!lcdEn) @(negedge clk);
    while (lcdEn) @(negedge clk);
    repeat (4) @(negedge clk);
    reqValid = 1'b1;
    reqRs    = 1'b0;
    reqByte  = 8'h55;
    @(negedge clk);
    reqValid = 1'b0;
    rises = 0;
    while (!reqReady) begin
      if (lcdEn) rises++;
      @(negedge clk);
    end
    checkVal("R11 no strobe from dropped request", rises, 0);
    sendReq(1'b1, 8'h42);
    watchTransfer("R11", "R8", 1'b1, 8'h42, WS, lead);

    // R1: reset during a strobe
    sendReq(1'b0, 8'h0C);
    while (!lcdEn) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkVal("R1 en after mid reset", int'(lcdEn), 0);
    checkVal("R1 drive after mid reset", int'(lcdDriveEn), 0);
    checkVal("R1 ready after mid reset", int'(reqReady), 0);
    checkVal("R1 rs after mid reset", int'(lcdRs), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule